// File: doc/BRIEF.md
# Zero common-mode level decomposer

This block sits between the reference generator and the carrier stage of an odd n-level three-phase inverter modulator. Once per sampling period it receives three normalized phase references. Each reference is already shifted by half the level span, so the three values add up to 3(n-1)/2, and that is the condition under which the common-mode voltage stays at zero. For each phase, the block splits the reference into an integer base level and a fractional active duty.

The block then adds up the three base levels and the three duties. From the sum of the base levels it works out which of the two zero-common-mode switching patterns applies. In the single-active pattern the duties add up to one step. In the double-active pattern they add up to two steps. A sample that fits neither pattern sets an error flag that stays set, and the previous outputs are kept. The results are registered and marked by a one-cycle valid pulse.

References are unsigned fixed point with 4 integer bits and 12 fractional bits, so one level step equals 4096 LSB. The level count is the parameter `N_LEVELS` (odd, default 3).

Top module: `zcm_level_split`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_vld`, `err_flag`, `pat_two` and every base, duty and sum output are zero.
- R2: For a reference below (N_LEVELS-1)*4096, the base level is the integer field, bits [15:12] of the reference.
- R3: A reference equal to (N_LEVELS-1)*4096 gives base level N_LEVELS-2 and a duty of 4096 (a full step). The base level never exceeds N_LEVELS-2.
- R4: Each phase duty equals the reference minus base*4096, and lies in 0..4096.
- R5: When the base levels add up to 3(N_LEVELS-1)/2-1 and the duties add up to 4096 within tolerance, the sample is accepted with `pat_two`=0.
- R6: When the base levels add up to 3(N_LEVELS-1)/2-2 and the duties add up to 8192 within tolerance, the sample is accepted with `pat_two`=1.
- R7: An accepted sample updates all outputs one clock after the cycle in which `smp_stb` is high, and `out_vld` is high for exactly that one cycle. Without a strobe the outputs do not change.
- R8: A strobed sample that matches neither pattern sets `err_flag`, keeps `out_vld` low and leaves all outputs unchanged. `err_flag` stays high until reset, and later good samples are still accepted.
- R9: The duty-sum tolerance is ±2 LSB: a deviation of 2 is accepted and a deviation of 3 is rejected as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| lvl_a | input | 16 | Phase A normalized reference, Q4.12 |
| lvl_b | input | 16 | Phase B normalized reference, Q4.12 |
| lvl_c | input | 16 | Phase C normalized reference, Q4.12 |
| out_vld | output | 1 | One-cycle pulse: the outputs hold a newly accepted sample |
| base_a | output | 4 | Phase A base level |
| base_b | output | 4 | Phase B base level |
| base_c | output | 4 | Phase C base level |
| duty_a | output | 13 | Phase A active duty, 4096 = full step |
| duty_b | output | 13 | Phase B active duty |
| duty_c | output | 13 | Phase C active duty |
| base_sum | output | 6 | Sum of the three base levels |
| duty_sum | output | 15 | Sum of the three duties |
| pat_two | output | 1 | 0 = single-active pattern, 1 = double-active pattern |
| err_flag | output | 1 | Sticky flag: a sample matched no pattern |

## Verification
The assertions take it for granted that every reference lies between 0 and (N_LEVELS-1)*4096 and that `smp_stb` is never high in two back-to-back cycles. The range limits on base and duty and the reconstruction check rely on that span. The stimulus uses only in-range values and always drops the strobe for at least one cycle between samples. Invalid samples are built by moving the reference sum away from 3(N_LEVELS-1)/2 steps, or by placing every reference below one step, so that the base-level sum misses both patterns.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

    localparam int INT_W  = 4;
    localparam int FRAC_W = 12;
    localparam int REF_W  = INT_W + FRAC_W;
    localparam int DUTY_W = FRAC_W + 1;
    localparam int BSUM_W = INT_W + 2;
    localparam int DSUM_W = DUTY_W + 2;
    localparam int NPH    = 3;
    localparam int TOL    = 2;

    typedef logic [REF_W-1:0]  lvl_t;
    typedef logic [INT_W-1:0]  base_t;
    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [BSUM_W-1:0] bsum_t;
    typedef logic [DSUM_W-1:0] dsum_t;

    typedef struct packed {
        base_t base;
        duty_t duty;
    } split_t;

    typedef enum logic [1:0] {
        PAT_NONE = 2'd0,
        PAT_ONE  = 2'd1,
        PAT_TWO  = 2'd2
    } pat_e;

    function automatic logic near(input dsum_t s, input dsum_t tgt);
        int d;
        d = int'(s) - int'(tgt);
        return (d >= -TOL) && (d <= TOL);
    endfunction

endpackage

// File: rtl/zcm_phase_split.sv
module zcm_phase_split
    import zcm_pkg::*;
#(
    parameter int N_LEVELS = 3
) (
    input  lvl_t   lvl_i,
    output split_t split_o
);
    localparam base_t TOP_BASE = base_t'(N_LEVELS - 2);
    localparam lvl_t  TOP_LVL  = lvl_t'((N_LEVELS - 1) << FRAC_W);

    base_t base;
    lvl_t  rem;

    always_comb begin
        if (lvl_i >= TOP_LVL) begin
            base = TOP_BASE;
        end else begin
            base = lvl_i[REF_W-1:FRAC_W];
        end
        rem = lvl_i - (lvl_t'(base) << FRAC_W);
        split_o.base = base;
        split_o.duty = rem[DUTY_W-1:0];
    end
endmodule

// File: rtl/zcm_sum_classify.sv
module zcm_sum_classify
    import zcm_pkg::*;
#(
    parameter int N_LEVELS = 3
) (
    input  split_t sp_i [NPH],
    output bsum_t  bsum_o,
    output dsum_t  dsum_o,
    output pat_e   pat_o
);
    localparam bsum_t SUM_ONE = bsum_t'((3 * (N_LEVELS - 1)) / 2 - 1);
    localparam bsum_t SUM_TWO = bsum_t'((3 * (N_LEVELS - 1)) / 2 - 2);
    localparam dsum_t STEP1   = dsum_t'(1 << FRAC_W);
    localparam dsum_t STEP2   = dsum_t'(2 << FRAC_W);

    always_comb begin
        bsum_o = '0;
        dsum_o = '0;
        for (int p = 0; p < NPH; p++) begin
            bsum_o = bsum_o + bsum_t'(sp_i[p].base);
            dsum_o = dsum_o + dsum_t'(sp_i[p].duty);
        end
        if (bsum_o == SUM_ONE && near(dsum_o, STEP1)) begin
            pat_o = PAT_ONE;
        end else if (bsum_o == SUM_TWO && near(dsum_o, STEP2)) begin
            pat_o = PAT_TWO;
        end else begin
            pat_o = PAT_NONE;
        end
    end
endmodule

// File: rtl/zcm_level_split.sv
module zcm_level_split
    import zcm_pkg::*;
#(
    parameter int N_LEVELS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [15:0]       lvl_a,
    input  logic [15:0]       lvl_b,
    input  logic [15:0]       lvl_c,
    output logic              out_vld,
    output logic [3:0]        base_a,
    output logic [3:0]        base_b,
    output logic [3:0]        base_c,
    output logic [12:0]       duty_a,
    output logic [12:0]       duty_b,
    output logic [12:0]       duty_c,
    output logic [5:0]        base_sum,
    output logic [14:0]       duty_sum,
    output logic              pat_two,
    output logic              err_flag
);
    lvl_t   lvl_in [NPH];
    split_t sp     [NPH];
    split_t sp_q   [NPH];
    bsum_t  bsum;
    dsum_t  dsum;
    pat_e   pat;
    bsum_t  bsum_q;
    dsum_t  dsum_q;

    assign lvl_in[0] = lvl_a;
    assign lvl_in[1] = lvl_b;
    assign lvl_in[2] = lvl_c;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        zcm_phase_split #(.N_LEVELS(N_LEVELS)) split_i (
            .lvl_i   (lvl_in[p]),
            .split_o (sp[p])
        );
    end

    zcm_sum_classify #(.N_LEVELS(N_LEVELS)) cls_i (
        .sp_i   (sp),
        .bsum_o (bsum),
        .dsum_o (dsum),
        .pat_o  (pat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            err_flag <= 1'b0;
            pat_two  <= 1'b0;
            bsum_q   <= '0;
            dsum_q   <= '0;
            for (int p = 0; p < NPH; p++) sp_q[p] <= '0;
        end else begin
            out_vld <= 1'b0;
            if (smp_stb) begin
                if (pat != PAT_NONE) begin
                    out_vld <= 1'b1;
                    pat_two <= (pat == PAT_TWO);
                    bsum_q  <= bsum;
                    dsum_q  <= dsum;
                    for (int p = 0; p < NPH; p++) sp_q[p] <= sp[p];
                end else begin
                    err_flag <= 1'b1;
                end
            end
        end
    end

    assign base_a   = sp_q[0].base;
    assign base_b   = sp_q[1].base;
    assign base_c   = sp_q[2].base;
    assign duty_a   = sp_q[0].duty;
    assign duty_b   = sp_q[1].duty;
    assign duty_c   = sp_q[2].duty;
    assign base_sum = bsum_q;
    assign duty_sum = dsum_q;
endmodule

// File: rtl/zcm_level_split_chk.sv
module zcm_level_split_chk
    import zcm_pkg::*;
#(
    parameter int N_LEVELS = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        smp_stb,
    input logic [15:0] lvl_a,
    input logic [15:0] lvl_b,
    input logic [15:0] lvl_c,
    input logic        out_vld,
    input logic [3:0]  base_a,
    input logic [3:0]  base_b,
    input logic [3:0]  base_c,
    input logic [12:0] duty_a,
    input logic [12:0] duty_b,
    input logic [12:0] duty_c,
    input logic [5:0]  base_sum,
    input logic [14:0] duty_sum,
    input logic        pat_two,
    input logic        err_flag
);
    localparam logic [3:0]  MAX_BASE = 4'(N_LEVELS - 2);
    localparam logic [12:0] FULL     = 13'(1 << FRAC_W);
    localparam logic [5:0]  S1       = 6'((3 * (N_LEVELS - 1)) / 2 - 1);
    localparam logic [5:0]  S2       = 6'((3 * (N_LEVELS - 1)) / 2 - 2);

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(smp_stb)); // R7
    AST_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(base_a) && $stable(duty_b) && $stable(duty_sum) && $stable(pat_two))); // R8
    AST_BASE_MAX: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (base_a <= MAX_BASE && base_b <= MAX_BASE && base_c <= MAX_BASE)); // R3
    AST_DUTY_SPAN: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (duty_a <= FULL && duty_b <= FULL && duty_c <= FULL)); // R4
    AST_RECON_A: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ((16'(base_a) << FRAC_W) + 16'(duty_a) == $past(lvl_a))); // R4
    AST_ONE_SUM: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !pat_two) |-> (base_sum == S1)); // R5
    AST_TWO_SUM: assert property (@(posedge clk) disable iff (rst)
        (out_vld && pat_two) |-> (base_sum == S2)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag); // R8
    AST_TOL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (pat_two ? (duty_sum >= 15'd8190 && duty_sum <= 15'd8194)
                             : (duty_sum >= 15'd4094 && duty_sum <= 15'd4098))); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && !err_flag)); // R1
endmodule

bind zcm_level_split zcm_level_split_chk #(.N_LEVELS(N_LEVELS)) chk_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .out_vld(out_vld), .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .base_sum(base_sum), .duty_sum(duty_sum), .pat_two(pat_two), .err_flag(err_flag)
);

// File: tb/zcm_level_split_tb_top.sv
`timescale 1ns/1ps
module zcm_level_split_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [15:0] lvl_a = '0, lvl_b = '0, lvl_c = '0;
    logic        out_vld, pat_two, err_flag;
    logic [3:0]  base_a, base_b, base_c;
    logic [12:0] duty_a, duty_b, duty_c;
    logic [5:0]  base_sum;
    logic [14:0] duty_sum;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zcm_level_split #(.N_LEVELS(3)) dut_i (
        .clk(clk), .rst(rst), .smp_stb(smp_stb),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
        .out_vld(out_vld), .base_a(base_a), .base_b(base_b), .base_c(base_c),
        .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
        .base_sum(base_sum), .duty_sum(duty_sum), .pat_two(pat_two), .err_flag(err_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Drive one strobed sample; return at the negedge after the capturing edge
    task automatic apply(input int a, input int b, input int c);
        @(negedge clk);
        lvl_a = 16'(a); lvl_b = 16'(b); lvl_c = 16'(c);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int ba, input int bb, input int bc,
                              input int da, input int db, input int dc,
                              input int bs, input int ds, input int p2);
        check({tag, " base_a"}, int'(base_a), ba);
        check({tag, " base_b"}, int'(base_b), bb);
        check({tag, " base_c"}, int'(base_c), bc);
        check({tag, " duty_a"}, int'(duty_a), da);
        check({tag, " duty_b"}, int'(duty_b), db);
        check({tag, " duty_c"}, int'(duty_c), dc);
        check({tag, " base_sum"}, int'(base_sum), bs);
        check({tag, " duty_sum"}, int'(duty_sum), ds);
        check({tag, " pat_two"}, int'(pat_two), p2);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 out_vld", int'(out_vld), 0);
        check("R1 err_flag", int'(err_flag), 0);
        expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_single();
        apply(6144, 5120, 1024);
        check("R7 out_vld pulse", int'(out_vld), 1);
        expect_out("R2 R5 single", 1, 1, 0, 2048, 1024, 1024, 2, 4096, 0);
        @(negedge clk);
        check("R7 out_vld drops", int'(out_vld), 0);
    endtask

    task automatic t_double();
        apply(2048, 3072, 7168);
        check("R6 out_vld", int'(out_vld), 1);
        expect_out("R4 R6 double", 0, 0, 1, 2048, 3072, 3072, 1, 8192, 1);
    endtask

    task automatic t_top_clamp();
        apply(8192, 4096, 0);
        check("R3 out_vld", int'(out_vld), 1);
        expect_out("R3 clamp", 1, 1, 0, 4096, 0, 0, 2, 4096, 0);
    endtask

    task automatic t_tol_ok();
        apply(6146, 5120, 1024);
        check("R9 plus2 accepted", int'(out_vld), 1);
        expect_out("R9 plus2", 1, 1, 0, 2050, 1024, 1024, 2, 4098, 0);
        check("R9 no error", int'(err_flag), 0);
        apply(6142, 5120, 1024);
        check("R9 minus2 accepted", int'(out_vld), 1);
        check("R9 minus2 duty_sum", int'(duty_sum), 4094);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        lvl_a = 16'd100; lvl_b = 16'd200; lvl_c = 16'd300;
        repeat (3) @(negedge clk);
        check("R7 no strobe vld", int'(out_vld), 0);
        expect_out("R7 no strobe hold", 1, 1, 0, 2046, 1024, 1024, 2, 4094, 0);
    endtask

    task automatic t_base_miss();
        apply(1000, 1000, 1000);
        check("R8 miss vld low", int'(out_vld), 0);
        check("R8 miss err", int'(err_flag), 1);
        expect_out("R8 miss hold", 1, 1, 0, 2046, 1024, 1024, 2, 4094, 0);
        apply(2048, 3072, 7168);
        check("R8 later accepted", int'(out_vld), 1);
        check("R8 err stays", int'(err_flag), 1);
        check("R8 later pat_two", int'(pat_two), 1);
    endtask

    task automatic t_tol_reject();
        do_reset();
        apply(6144, 5120, 1024);
        apply(6147, 5120, 1024);
        check("R9 plus3 vld low", int'(out_vld), 0);
        check("R9 plus3 err", int'(err_flag), 1);
        check("R9 plus3 hold duty_a", int'(duty_a), 2048);
        check("R9 plus3 hold duty_sum", int'(duty_sum), 4096);
    endtask

    initial begin
        t_reset();
        t_single();
        t_double();
        t_top_clamp();
        t_tol_ok();
        t_no_strobe();
        t_base_miss();
        t_tol_reject();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule